// File: doc/BRIEF.md
# Asynchronous PSRAM Access Controller

This block sits between a synchronous host and an asynchronous pseudo-static RAM of 512K words by 16 bits. Each host request is one word: a read, or a write with per-byte enables. The controller turns that request into a timed sequence on the memory's chip-select, output-enable, write-enable and byte-lane strobes. It drives the outgoing data bus together with an enable for an external tristate buffer. It samples returned read data and hands it back with a one-cycle valid strobe.

Every memory timing limit is a parameter in nanoseconds. Each limit is turned into a whole number of clock cycles by rounding up against the clock-period parameter. A cycle is always opened by chip-select and the read or write strobe falling on the same edge, and closed by them rising together. Chip-select then stays high for a guaranteed gap, which gives the memory time for internal refresh and standby entry. Whenever no request is in flight, the chip is left deselected.

Top module: `psram_seq`

## Requirements
- R1: After reset, and whenever no request is in flight, chip-select, output-enable, write-enable and both byte-lane strobes are high (inactive), the data driver enable is low, rd_valid is low and req_ready is high.
- R2: A read lowers chip-select and output-enable on the same edge. It keeps them low for at least 65 ns counted from chip-select and at least 40 ns counted from output-enable. It samples mem_dq_i on the edge where both rise. rd_valid then pulses high for exactly one clock with that word on rd_data.
- R3: During a read both byte-lane strobes are low, whatever req_be holds, and the full 16-bit word is returned.
- R4: A write lowers chip-select and write-enable together for at least 45 ns. The lower-lane strobe is low exactly when req_be[0] is 1, and the upper-lane strobe is low exactly when req_be[1] is 1. With req_be = 2'b00 the stored word does not change.
- R5: mem_dq_oe is high only while a write strobe is low, and it is high for the whole write strobe. The write data is stable for at least 15 ns before the write strobe rises.
- R6: Chip-select stays high for at least 12 ns between cycles. One cycle start to the next is at least 70 ns apart.
- R7: Output-enable and write-enable are low only while chip-select is low, and never both at once. Neither falls sooner than 10 ns after chip-select last rose.
- R8: Chip-select is never held low for more than 1 us, and chip-select low with both other strobes high never occurs.
- R9: The data driver enable has been low for at least one full clock when output-enable falls.
- R10: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is low from that edge until the cycle's chip-select-high gap has run its length.
- R11: Each strobe interval equals its nanosecond limit rounded up to whole clock periods. With a 4 ns clock a read strobe lasts 68 ns and a write strobe lasts 48 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_be | input | 2 | Byte enables for writes (bit 0 lower byte, bit 1 upper byte) |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the read word |
| rd_data | output | 16 | Returned read word |
| mem_addr | output | 19 | Memory address |
| mem_ce1_n | output | 1 | Chip-select, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_we_n | output | 1 | Write-enable, active low |
| mem_lb_n | output | 1 | Lower byte lane strobe, active low |
| mem_ub_n | output | 1 | Upper byte lane strobe, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the external data tristate buffer |
| mem_dq_i | input | 16 | Data returned from the memory |

## Verification
The hardest case to provoke is a read that follows a write straight away to the same address. In that case the bus turnaround, the chip-select gap and the access-time wait all meet in a few clocks. The bench's memory model helps here: it returns a poison word until both access windows, measured in nanoseconds from the strobe falls, have run out. Any sample taken even one clock early therefore shows up as wrong data. Directed write/read pairs on the same address, with partial byte enables, are mixed into a seeded random stream of back-to-back operations with random idle gaps.

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
module psram_seq #(
  parameter int CLK_NS      = 4,
  parameter int AW          = 19,
  parameter int DW          = 16,
  parameter int T_CYCLE_NS  = 70,
  parameter int T_ACCESS_NS = 65,
  parameter int T_OE_ACC_NS = 40,
  parameter int T_WPULSE_NS = 45,
  parameter int T_WREC_NS   = 10,
  parameter int T_DSETUP_NS = 15,
  parameter int T_CEHIGH_NS = 12,
  parameter int T_STBY_NS   = 10,
  parameter int T_SELMAX_NS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  function automatic int cdiv(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_ACT  = imax(cdiv(T_ACCESS_NS), cdiv(T_OE_ACC_NS));
  localparam int WR_ACT  = imax(cdiv(T_WPULSE_NS), cdiv(T_DSETUP_NS));
  localparam int GAP_MIN = imax(1, imax(cdiv(T_CEHIGH_NS), imax(cdiv(T_WREC_NS), cdiv(T_STBY_NS))));
  localparam int CYC     = cdiv(T_CYCLE_NS);
  localparam int RD_GAP  = imax(GAP_MIN, CYC - RD_ACT);
  localparam int WR_GAP  = imax(GAP_MIN, CYC - WR_ACT);
  localparam int CNT_MAX = imax(imax(RD_ACT, WR_ACT), imax(RD_GAP, WR_GAP));
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int SEL_MAX = T_SELMAX_NS / CLK_NS;
  localparam int SW      = $clog2(SEL_MAX + 2);
  localparam int HW      = $clog2(GAP_MIN + 1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          take;

  assign req_ready = (st == S_IDLE) || (st == S_GAP && cnt == '0);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_ce1_n <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (take) begin
        mem_addr  <= req_addr;
        mem_ce1_n <= 1'b0;
        if (req_write) begin
          mem_dq_o  <= req_wdata;
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          mem_lb_n  <= ~req_be[0];
          mem_ub_n  <= ~req_be[1];
          st        <= S_WR;
          cnt       <= CW'(WR_ACT - 1);
        end else begin
          mem_oe_n <= 1'b0;
          mem_lb_n <= 1'b0;
          mem_ub_n <= 1'b0;
          st       <= S_RD;
          cnt      <= CW'(RD_ACT - 1);
        end
      end else begin
        case (st)
          S_RD: begin
            if (cnt == '0) begin
              mem_ce1_n <= 1'b1;
              mem_oe_n  <= 1'b1;
              mem_lb_n  <= 1'b1;
              mem_ub_n  <= 1'b1;
              rd_data   <= mem_dq_i;
              rd_valid  <= 1'b1;
              st        <= S_GAP;
              cnt       <= CW'(RD_GAP - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_WR: begin
            if (cnt == '0) begin
              mem_ce1_n <= 1'b1;
              mem_we_n  <= 1'b1;
              mem_lb_n  <= 1'b1;
              mem_ub_n  <= 1'b1;
              mem_dq_oe <= 1'b0;
              st        <= S_GAP;
              cnt       <= CW'(WR_GAP - 1);
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_GAP: begin
            if (cnt == '0) st <= S_IDLE;
            else cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  logic [SW-1:0] sel_run;
  logic [HW-1:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_run  <= '0;
      high_run <= HW'(GAP_MIN);
    end else begin
      if (!mem_ce1_n) sel_run <= (sel_run == SW'(SEL_MAX + 1)) ? sel_run : sel_run + 1'b1;
      else sel_run <= '0;
      if (!mem_ce1_n) high_run <= '0;
      else if (high_run != HW'(GAP_MIN)) high_run <= high_run + 1'b1;
    end
  end

  a_r2_rdv_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!mem_oe_n) && mem_oe_n));
  a_r2_rdv_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r3_read_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_lb_n && !mem_ub_n));
  a_r5_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && !mem_ce1_n));
  a_r7_strobes_under_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_ce1_n);
  a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  a_r8_select_limit: assert property (@(posedge clk) disable iff (!rst_n)
    sel_run <= SW'(SEL_MAX));
  a_r6_high_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce1_n) |-> (high_run >= HW'(GAP_MIN)));
  a_r9_release_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce1_n |-> !req_ready);

endmodule

// File: tb/psram_seq_tb_top.sv
`timescale 1ns/1ps
module psram_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [18:0] mem_addr;
  logic        mem_ce1_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = 16'hDEAD;

  always #2 clk = ~clk;

  psram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $realtime);
    end
  endtask

  function automatic int ns_to_clk(input int ns);
    return (ns + 3) / 4;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  logic [18:0] addrs [8] = '{19'h00000, 19'h00001, 19'h00002, 19'h00003,
                             19'h40000, 19'h7FFFF, 19'h2AAAA, 19'h55555};

  function automatic int slot(input logic [18:0] a);
    for (int i = 0; i < 8; i++) if (addrs[i] == a) return i;
    return 0;
  endfunction

  logic [15:0] store   [8];
  logic [15:0] exp_mem [8];
  initial for (int i = 0; i < 8; i++) begin store[i] = '0; exp_mem[i] = '0; end

  realtime t_cef = -1000.0, t_cer = -1000.0, t_oef = -1000.0, t_wef = -1000.0;
  realtime t_dq = -1000.0, t_dqoef = -1000.0;
  bit      seen_cycle = 1'b0;
  int      v7 = 0, vlane = 0, vdrv = 0, sel_ns = 0, sel_max = 0, od_ns = 0, od_max = 0;
  logic    w_lb = 1'b1, w_ub = 1'b1;
  logic [15:0] w_d = '0;

  always @(negedge mem_ce1_n) if (rst_n) begin
    if (seen_cycle) chk(($realtime - t_cef) >= 70.0, "R6 cycle", int'($realtime - t_cef), 70);
    chk(($realtime - t_cer) >= 12.0, "R6 gap", int'($realtime - t_cer), 12);
    seen_cycle = 1'b1;
    t_cef = $realtime;
  end
  always @(posedge mem_ce1_n) t_cer = $realtime;
  always @(mem_dq_o) t_dq = $realtime;
  always @(negedge mem_dq_oe) t_dqoef = $realtime;

  always @(negedge mem_oe_n) if (rst_n) begin
    t_oef = $realtime;
    chk(($realtime - t_cer) >= 10.0, "R7 oe spacing", int'($realtime - t_cer), 10);
    chk(($realtime - t_dqoef) >= 4.0, "R9", int'($realtime - t_dqoef), 4);
  end
  always @(posedge mem_oe_n) if (rst_n) begin
    chk(($realtime - t_cef) >= 65.0, "R2 ce access", int'($realtime - t_cef), 65);
    chk(($realtime - t_oef) >= 40.0, "R2 oe access", int'($realtime - t_oef), 40);
    chk(($realtime - t_oef) == real'(4 * ns_to_clk(65)), "R11 read width",
        int'($realtime - t_oef), 4 * ns_to_clk(65));
  end

  always @(negedge mem_we_n) if (rst_n) begin
    t_wef = $realtime;
    chk(($realtime - t_cer) >= 10.0, "R7 we spacing", int'($realtime - t_cer), 10);
  end
  always @(posedge mem_we_n) if (rst_n) begin
    chk(($realtime - t_wef) >= 45.0, "R4 pulse", int'($realtime - t_wef), 45);
    chk(($realtime - t_wef) == real'(4 * ns_to_clk(45)), "R11 write width",
        int'($realtime - t_wef), 4 * ns_to_clk(45));
    chk(($realtime - t_dq) >= 15.0, "R5 setup", int'($realtime - t_dq), 15);
    store[slot(mem_addr)] = {w_ub ? store[slot(mem_addr)][15:8] : w_d[15:8],
                             w_lb ? store[slot(mem_addr)][7:0]  : w_d[7:0]};
  end

  initial begin
    #0.5;
    forever begin
      if (rst_n) begin
        if (!mem_ce1_n && !mem_oe_n && mem_we_n &&
            ($realtime - t_cef) >= 65.0 && ($realtime - t_oef) >= 40.0)
          mem_dq_i = store[slot(mem_addr)];
        else
          mem_dq_i = 16'hDEAD;
        if (((!mem_oe_n || !mem_we_n) && mem_ce1_n) || (!mem_oe_n && !mem_we_n)) v7++;
        if (!mem_oe_n && (mem_lb_n || mem_ub_n)) vlane++;
        if ((mem_dq_oe && mem_we_n) || (!mem_we_n && !mem_dq_oe)) vdrv++;
        if (!mem_ce1_n) sel_ns++; else sel_ns = 0;
        if (sel_ns > sel_max) sel_max = sel_ns;
        if (!mem_ce1_n && mem_oe_n && mem_we_n) od_ns++; else od_ns = 0;
        if (od_ns > od_max) od_max = od_ns;
        if (!mem_we_n) begin w_lb = mem_lb_n; w_ub = mem_ub_n; w_d = mem_dq_o; end
      end
      #1;
    end
  end

  task automatic do_op(input bit wr, input int s, input logic [1:0] be, input logic [15:0] d);
    int n;
    n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addrs[s]; req_be = be; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 busy", {31'd0, req_ready}, 0);
    if (wr) begin
      exp_mem[s] = merge(exp_mem[s], d, be);
    end else begin
      while (!rd_valid && n < 100) begin @(negedge clk); n++; end
      chk(rd_valid && rd_data == exp_mem[s], "R2 data", {16'd0, rd_data}, {16'd0, exp_mem[s]});
      @(negedge clk);
      chk(!rd_valid, "R2 pulse", {31'd0, rd_valid}, 0);
    end
  endtask

  task automatic run_all();
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk(mem_ce1_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe && !rd_valid,
        "R1 in reset", {27'd0, mem_ce1_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1f);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce1_n && !mem_dq_oe, "R1 after reset", {31'd0, req_ready}, 1);

    for (int i = 0; i < 8; i++) do_op(1'b1, i, 2'b11, 16'h1000 + 16'(i));
    for (int i = 0; i < 8; i++) do_op(1'b0, i, 2'b11, 16'h0);

    do_op(1'b1, 5, 2'b11, 16'hFFFF);
    do_op(1'b1, 5, 2'b01, 16'h1234);
    do_op(1'b0, 5, 2'b00, 16'h0);
    chk(exp_mem[5] == 16'hFF34, "R4 lower lane", {16'd0, exp_mem[5]}, 32'hFF34);
    do_op(1'b1, 5, 2'b10, 16'hABCD);
    do_op(1'b0, 5, 2'b01, 16'h0);
    do_op(1'b1, 5, 2'b00, 16'h5555);
    do_op(1'b0, 5, 2'b10, 16'h0);
    chk(rd_data == 16'hAB34, "R3 R4 byte merge", {16'd0, rd_data}, 32'hAB34);

    repeat (300) @(negedge clk);
    chk(mem_ce1_n && req_ready, "R1 R8 idle deselect", {31'd0, mem_ce1_n}, 1);

    for (int i = 0; i < 120; i++) begin
      bit          wr;
      int          s;
      logic [15:0] d;
      wr = 1'($urandom % 2);
      s  = int'($urandom % 8);
      d  = 16'($urandom);
      if (d == 16'hDEAD) d = 16'h0001;
      do_op(wr, s, 2'($urandom), d);
      if (wr && ($urandom % 3 == 0)) do_op(1'b0, s, 2'($urandom), 16'h0);
      repeat ($urandom % 4) @(negedge clk);
    end

    repeat (30) @(negedge clk);
    chk(v7 == 0, "R7 strobe order", v7, 0);
    chk(vlane == 0, "R3 read lanes", vlane, 0);
    chk(vdrv == 0, "R5 driver window", vdrv, 0);
    chk(sel_max <= 1000, "R8 select time", sel_max, 1000);
    chk(od_max == 0, "R8 output disable", od_max, 0);
    chk(req_ready && mem_ce1_n && !mem_dq_oe, "R1 final idle", {31'd0, req_ready}, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hang expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule